// File: doc/BRIEF.md
# BERT transmit error injector

This block sits on the serial output of a test pattern generator and deliberately corrupts chosen bits, so that the receiving bit-error checker can be shown to count errors correctly. Each clock cycle with the bit-valid input high carries one data bit. The block passes that bit through unchanged, or passes it out inverted. On every inverted bit it raises a one-cycle strobe.

Errors come from two sources. The first is periodic: a 3-bit exponent k selects one inverted bit in every 10^k valid bits, and k = 0 turns the periodic source off. The active exponent is captured when counting starts and again each time an error is injected, so a new exponent written in the middle of an interval waits until that interval has ended. The second source is a single-shot input. Its rising edge arms one pending error, which lands on the next valid bit. Several edges before that bit still produce only one error. A master enable held low stops both sources and clears any armed state.

Top module: `bert_err_inject`

## Requirements
- R1: Out of reset, and whenever no error is due, `bit_o` equals `bit_i` and `err_o` is 0.
- R2: When the enable is high and the exponent k is between 1 and 7, the bit is inverted on valid bits number 10^k, 2·10^k, and so on. Numbering starts with the first valid bit that arrives at least one clock after k became nonzero with the enable high.
- R3: An active exponent of 0 injects no periodic errors. When the exponent is set to 0 in the middle of an interval, the interval in progress still ends with one error, and no periodic errors follow.
- R4: An exponent change during an interval does not shift that interval's error. The new period applies starting from the error that ends the interval.
- R5: While `ins_en_i` is 0, no bit is inverted. A single-shot edge seen during that time is dropped, and periodic counting restarts from the beginning once the enable returns.
- R6: A rising edge on `single_i`, sampled at a clock edge, inverts exactly one bit. That bit is the first valid bit in a later cycle.
- R7: Several rising edges on `single_i` before the next valid bit produce only one inverted bit.
- R8: When a periodic error and a pending single-shot error fall on the same bit, the bit is inverted once. Both sources count as served: the single-shot request clears, and the periodic interval reloads.
- R9: `err_o` is 1 exactly on the cycles where `bit_o` differs from `bit_i`. Those cycles always have `bit_vld_i` = 1.
- R10: Cycles with `bit_vld_i` = 0 leave the periodic count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_vld_i | input | 1 | Marks a cycle that carries a data bit |
| bit_i | input | 1 | Data bit from the pattern generator |
| ins_en_i | input | 1 | Master enable for both error sources |
| rate_exp_i | input | 3 | Periodic rate exponent k (one error per 10^k bits, 0 = off) |
| single_i | input | 1 | Single-shot request; a rising edge arms one error |
| bit_o | output | 1 | Data bit after possible inversion |
| err_o | output | 1 | High on each inverted bit |

## Verification
The assertions assume that all inputs change synchronously to the clock and that the exponent never exceeds 7. A rising edge on `single_i` is assumed not to fall in the same cycle as the valid bit that serves an earlier request. The bench changes inputs only in the low phase of the clock. It raises the single-shot input only in cycles without a valid bit, and uses only exponents 1 to 3 so that whole periods fit in the run. An enable-low cycle followed by one idle load cycle starts every sequence from a known count.

// File: rtl/bei_pkg.sv
package bei_pkg;
  localparam int unsigned EXP_W = 3;
  localparam int unsigned CNT_W = 24;
  localparam int unsigned MAX_EXP = 7;

  function automatic int unsigned pow10(input int unsigned k);
    int unsigned r;
    r = 1;
    for (int unsigned i = 0; i < MAX_EXP; i++)
      if (i < k) r = r * 10;
    return r;
  endfunction
endpackage

// File: rtl/bei_rate_ctr.sv
module bei_rate_ctr
  import bei_pkg::*;
#(
  parameter int unsigned EW = EXP_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          vld_i,
  input  logic [EW-1:0] rate_i,
  output logic          hit_o
);
  localparam int unsigned MAX_PER = pow10(MAX_EXP);

  logic [EW-1:0] act_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] reload;
  logic          idle;

  assign idle   = (act_q == '0);
  assign reload = (rate_i == '0) ? '0 : CW'(pow10(int'(rate_i)));
  assign hit_o  = en_i && vld_i && !idle && (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      cnt_q <= '0;
    end else if (!en_i) begin
      act_q <= '0;
      cnt_q <= '0;
    end else if (idle || hit_o) begin
      // new exponent is taken only here
      act_q <= rate_i;
      cnt_q <= reload;
    end else if (vld_i) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // R10
  gap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !idle && !vld_i |=> $stable(cnt_q));

  // R2
  count_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && vld_i && !idle && (cnt_q > CW'(1)) |=> cnt_q == $past(cnt_q) - CW'(1));

  // R4
  rate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !idle && !hit_o |=> act_q == $past(act_q));

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle |-> (cnt_q != '0) && (cnt_q <= CW'(MAX_PER)));
endmodule

// File: rtl/bei_single.sv
module bei_single (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic vld_i,
  input  logic req_i,
  output logic pend_o
);
  logic req_q;
  logic pend_q;
  logic rise;

  assign rise   = req_i && !req_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pend_q <= 1'b0;
    else if (!en_i)           pend_q <= 1'b0;
    else if (vld_i && pend_q) pend_q <= rise;
    else                      pend_q <= pend_q || rise;
  end

  // R6
  served_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && vld_i && pend_q && !rise |=> !pend_q);

  // R7
  armed_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && pend_q && !vld_i |=> pend_q);

  // R5
  drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pend_q);
endmodule

// File: rtl/bert_err_inject.sv
module bert_err_inject
  import bei_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_vld_i,
  input  logic             bit_i,
  input  logic             ins_en_i,
  input  logic [EXP_W-1:0] rate_exp_i,
  input  logic             single_i,
  output logic             bit_o,
  output logic             err_o
);
  logic rate_hit;
  logic pend;
  logic inv;

  bei_rate_ctr #(.EW(EXP_W), .CW(CNT_W)) u_rate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ins_en_i),
    .vld_i  (bit_vld_i),
    .rate_i (rate_exp_i),
    .hit_o  (rate_hit)
  );

  bei_single u_single (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ins_en_i),
    .vld_i  (bit_vld_i),
    .req_i  (single_i),
    .pend_o (pend)
  );

  // coincident sources invert once
  assign inv   = rate_hit || (ins_en_i && bit_vld_i && pend);
  assign err_o = inv;
  assign bit_o = bit_i ^ inv;

  // R9
  err_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> bit_vld_i && ins_en_i);

  // R8
  coincide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_hit && pend && !(single_i && !$past(single_i)) |=> !pend);
endmodule

// File: tb/bert_err_inject_bench.sv
`timescale 1ns/1ps
module bert_err_inject_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_vld_i = 1'b0;
  logic       bit_i = 1'b0;
  logic       ins_en_i = 1'b0;
  logic [2:0] rate_exp_i = 3'd0;
  logic       single_i = 1'b0;
  logic       bit_o;
  logic       err_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  bert_err_inject u_bert_err_inject (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .bit_vld_i  (bit_vld_i),
    .bit_i      (bit_i),
    .ins_en_i   (ins_en_i),
    .rate_exp_i (rate_exp_i),
    .single_i   (single_i),
    .bit_o      (bit_o),
    .err_o      (err_o)
  );

  typedef struct packed {
    logic [2:0]  k;
    logic        gap;
    logic [15:0] n;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{k: 3'd1, gap: 1'b0, n: 16'd45},
    '{k: 3'd1, gap: 1'b1, n: 16'd33},
    '{k: 3'd2, gap: 1'b1, n: 16'd230},
    '{k: 3'd3, gap: 1'b0, n: 16'd2050}
  };

  function automatic int p10(input int k);
    int r = 1;
    for (int i = 0; i < k; i++) r = r * 10;
    return r;
  endfunction

  task automatic chk(input string tag, input logic exp_err, input logic exp_bit);
    n_chk++;
    if (err_o !== exp_err || bit_o !== exp_bit) begin
      n_bad++;
      $display("FAIL %s: err_o=%b bit_o=%b expected err_o=%b bit_o=%b",
               tag, err_o, bit_o, exp_err, exp_bit);
    end
  endtask

  task automatic step(input logic v, input logic b, input logic s);
    @(negedge clk);
    bit_vld_i = v;
    bit_i     = b;
    single_i  = s;
    #1;
  endtask

  // first: index of a lone/first error (0 = none); period: spacing after it (0 = none)
  task automatic stream(input string tag, input int n, input int first,
                        input int period, input logic gap);
    logic b, e;
    for (int i = 1; i <= n; i++) begin
      if (gap) begin
        step(1'b0, i[0], single_i);
        chk(tag, 1'b0, i[0]);
      end
      b = ^i[4:0];
      e = (first > 0 && i == first) ||
          (period > 0 && first > 0 && i > first && ((i - first) % period) == 0);
      step(1'b1, b, single_i);
      chk(tag, e, b ^ e);
    end
  endtask

  task automatic restart(input logic [2:0] k);
    ins_en_i = 1'b0;
    step(1'b0, 1'b0, 1'b0);
    ins_en_i   = 1'b1;
    rate_exp_i = k;
    step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    report();
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    bit_i = 1'b1;
    #1;
    chk("R1", 1'b0, 1'b1);
    bit_i = 1'b0;
    #1;
    chk("R1", 1'b0, 1'b0);
    rst_ni = 1'b1;
    ins_en_i = 1'b1;
    step(1'b0, 1'b0, 1'b0);

    // R3: zero exponent, no periodic errors
    stream("R3", 25, 0, 0, 1'b0);

    // R2 / R10: table of rates, with and without gap cycles
    foreach (VECS[v]) begin
      restart(VECS[v].k);
      stream(VECS[v].gap ? "R10" : "R2", int'(VECS[v].n),
             p10(int'(VECS[v].k)), p10(int'(VECS[v].k)), VECS[v].gap);
    end

    // R4: change 1 -> 2 after 5 bits; interval finishes at old rate
    restart(3'd1);
    stream("R4", 5, 0, 0, 1'b0);
    rate_exp_i = 3'd2;
    stream("R4", 120, 5, 100, 1'b0);
    // R3: exponent set to 0 mid-interval; 85 bits remain, then nothing
    rate_exp_i = 3'd0;
    stream("R3", 150, 85, 0, 1'b0);

    // R5: enable low blocks both sources and drops the request
    ins_en_i   = 1'b0;
    rate_exp_i = 3'd1;
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    stream("R5", 30, 0, 0, 1'b0);
    rate_exp_i = 3'd0;
    ins_en_i   = 1'b1;
    step(1'b0, 1'b0, 1'b0);
    stream("R5", 10, 0, 0, 1'b0);

    // R6: one edge, one error on the next valid bit
    step(1'b0, 1'b0, 1'b1);
    chk("R6", 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    stream("R6", 20, 1, 0, 1'b0);

    // R7: several edges before the opportunity collapse to one
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    chk("R7", 1'b0, 1'b0);
    stream("R7", 20, 1, 0, 1'b0);

    // R8: single-shot armed for the same bit as a periodic error
    restart(3'd1);
    stream("R8", 9, 0, 0, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    chk("R8", 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1);
    chk("R8", 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    chk("R9", 1'b0, 1'b0);
    stream("R8", 25, 10, 10, 1'b0);

    report();
    $finish;
  end
endmodule